// File: doc/BRIEF.md
# Dual-Channel Serial Converter Output Emulator

This block plays the device side of a two-channel 12-bit converter's serial interface. A host controller drives an active-low chip select, a serial clock and a mode pin. The emulator shifts out two's-complement sample words that a parallel source presents on two input buses. It is intended as a synthesizable stand-in for the real converter, so that host-side serial receive logic can be built and tested without the analog part. Each serial output has its own enable, which models the high-impedance state of a real pin.

All inputs are oversampled by the block's own system clock. Chip select and the serial clock pass through a configurable synchronizer, and their edges are detected in the system clock domain. While chip select is low, the serial clock's falling edges are counted into slots of a fixed length. Every slot begins with a run of zero bits, then sends one word MSB first, then pads with zeros until the slot is full. With the mode pin high at the start of a frame, both channels leave at the same time on separate lines. With the mode pin low, line A carries channel A's word in one slot and channel B's word in the next, and line B stays disabled.

Top module: `adc_dual_serial_emu`

## Requirements
- R1: After reset, both data outputs and both output enables are 0.
- R2: A synchronized falling edge of `cs_n` raises `dout_a_oe`. A synchronized rising edge clears both enables. Whenever an enable is 0, its data output is 0.
- R3: In each slot, the first `LEAD_ZEROS` serial-clock falling edges drive 0. The word's MSB is driven on falling edge `LEAD_ZEROS+1`, and the lower bits follow in descending order on each later falling edge. Bits change only on falling edges of `sclk`.
- R4: If `dual_mode` is 1 when the frame opens, `dout_b_oe` rises with `dout_a_oe`, and channel B's word is shifted on `dout_b` in the same bit positions as channel A's word on `dout_a`.
- R5: If `dual_mode` is 0 when the frame opens, `dout_a` carries channel A's word in the first slot and channel B's word in the second slot, alternating for the rest of the frame. `dout_b_oe` stays 0 for the whole frame.
- R6: While `cs_n` stays low, the falling edge after the last one of a slot is the first edge of the next slot. There are no idle cycles between slots.
- R7: Both sample inputs are captured when a frame opens and when a slot that precedes a channel-A slot ends. Input changes during a slot do not affect that slot. In single-line mode, the channel-B slot sends the word captured together with the preceding channel-A word.
- R8: If `cs_n` rises before a slot is complete, both enables drop. The next frame starts with a channel-A slot, leading zeros and freshly captured samples.
- R9: Falling edges of `sclk` while `cs_n` is high are ignored. The enables stay 0, and the next frame still starts at slot position 1.
- R10: Changes of `dual_mode` after the frame has opened have no effect on routing or enables until the next frame.
- R11: When `SLOT_LEN` exceeds `LEAD_ZEROS+DATA_W`, the falling edges after the LSB drive 0 until the slot ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples all interface inputs |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select; frames the conversion window |
| sclk | input | 1 | Serial clock from the host; bits change on its falling edges |
| dual_mode | input | 1 | 1 = one line per channel, 0 = both channels on line A |
| sample_a | input | DATA_W | Channel A two's-complement sample word |
| sample_b | input | DATA_W | Channel B two's-complement sample word |
| dout_a | output | 1 | Serial data line A |
| dout_a_oe | output | 1 | Drive enable for line A (0 = high impedance) |
| dout_b | output | 1 | Serial data line B |
| dout_b_oe | output | 1 | Drive enable for line B (0 = high impedance) |

## Verification
The bench builds the block with `DATA_W=12`, `LEAD_ZEROS=4` and `SYNC_STAGES=2`, but with `SLOT_LEN=18` instead of the default 16. The longer slot gives two trailing zero positions, so the padding after the LSB is observable. It also places the capture point two edges after the LSB, so the bench can tell the capture point apart from the last data bit. The serial clock runs at one sixteenth of the system clock, which leaves room for the synchronizer latency before each sample point. The sample words are chosen so that both sign extremes and single-bit patterns pass through both lines.

// File: rtl/emu_pkg.sv
package emu_pkg;

   // Which channel owns the current slot on line A
   typedef enum logic {
      SLOT_CH_A = 1'b0,
      SLOT_CH_B = 1'b1
   } slot_ch_e;

   // Edge events seen in the system clock domain
   typedef struct packed {
      logic cs_fall;
      logic cs_rise;
      logic sclk_fall;
   } emu_evt_t;

   localparam int unsigned NUM_LANES = 2;

endpackage

// File: rtl/emu_sync.sv
module emu_sync #(
   parameter int unsigned STAGES  = 2,
   parameter logic        RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [STAGES-1:0] chain_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               chain_q <= {STAGES{RST_VAL}};
            end else if (STAGES == 1) begin
               chain_q[0] <= d;
            end else begin
               chain_q <= {chain_q[STAGES-2:0], d};
            end
         end
         assign q = chain_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/emu_front.sv
module emu_front
   import emu_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     cs_n,
   input  logic     sclk,
   output emu_evt_t evt
);

   logic cs_s, sclk_s;
   logic cs_prev, sclk_prev;

   emu_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_cs (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (cs_n),
      .q     (cs_s)
   );

   emu_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_sclk (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (sclk),
      .q     (sclk_s)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_prev   <= 1'b1;
         sclk_prev <= 1'b1;
      end else begin
         cs_prev   <= cs_s;
         sclk_prev <= sclk_s;
      end
   end

   always_comb begin
      evt.cs_fall   = cs_prev & ~cs_s;
      evt.cs_rise   = ~cs_prev & cs_s;
      evt.sclk_fall = sclk_prev & ~sclk_s;
   end

endmodule

// File: rtl/emu_slot_ctrl.sv
module emu_slot_ctrl
   import emu_pkg::*;
#(
   parameter int unsigned SLOT_LEN = 16,
   parameter int unsigned POS_W    = $clog2(SLOT_LEN + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  emu_evt_t         evt,
   input  logic             dual_in,
   output logic             frame_start,
   output logic             frame_end,
   output logic             fall_act,
   output logic [POS_W-1:0] pos_n,
   output logic             latch_en,
   output logic             dual_q,
   output slot_ch_e         slot_ch
);

   localparam logic [POS_W-1:0] LAST_POS = POS_W'(SLOT_LEN);
   localparam logic [POS_W-1:0] ONE_POS  = POS_W'(1);

   logic             active_q;
   logic [POS_W-1:0] pos_q;
   logic             wrap;
   logic             slot_done;

   assign frame_start = evt.cs_fall;
   assign frame_end   = evt.cs_rise;
   assign fall_act    = active_q & evt.sclk_fall & ~evt.cs_rise & ~evt.cs_fall;

   // Position reached by the current falling edge, 1..SLOT_LEN
   assign wrap      = (pos_q == LAST_POS);
   assign pos_n     = wrap ? ONE_POS : pos_q + ONE_POS;
   assign slot_done = fall_act & (pos_n == LAST_POS);

   // Capture when the frame opens, or when a slot that precedes an A slot ends
   assign latch_en = frame_start |
                     (slot_done & (dual_q | (slot_ch == SLOT_CH_B)));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         pos_q    <= '0;
         dual_q   <= 1'b0;
         slot_ch  <= SLOT_CH_A;
      end else if (frame_start) begin
         active_q <= 1'b1;
         pos_q    <= '0;
         dual_q   <= dual_in;
         slot_ch  <= SLOT_CH_A;
      end else if (frame_end) begin
         active_q <= 1'b0;
         pos_q    <= '0;
         slot_ch  <= SLOT_CH_A;
      end else if (fall_act) begin
         pos_q <= pos_n;
         if (wrap && !dual_q) begin
            slot_ch <= (slot_ch == SLOT_CH_A) ? SLOT_CH_B : SLOT_CH_A;
         end
      end
   end

endmodule

// File: rtl/emu_lane.sv
module emu_lane #(
   parameter int unsigned DATA_W     = 12,
   parameter int unsigned LEAD_ZEROS = 4,
   parameter int unsigned POS_W      = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_start,
   input  logic              frame_end,
   input  logic              lane_en,
   input  logic              fall_act,
   input  logic [POS_W-1:0]  pos_n,
   input  logic [DATA_W-1:0] word,
   output logic              dout,
   output logic              oe
);

   localparam logic [POS_W-1:0] MSB_POS  = POS_W'(LEAD_ZEROS + 1);
   localparam logic [POS_W-1:0] LSB_POS  = POS_W'(LEAD_ZEROS + DATA_W);

   logic [DATA_W-1:0] shreg;
   logic              in_data;

   assign in_data = (pos_n > MSB_POS) && (pos_n <= LSB_POS);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         oe    <= 1'b0;
         dout  <= 1'b0;
         shreg <= '0;
      end else if (frame_start) begin
         oe    <= lane_en;
         dout  <= 1'b0;
         shreg <= '0;
      end else if (frame_end) begin
         oe    <= 1'b0;
         dout  <= 1'b0;
         shreg <= '0;
      end else if (fall_act && oe) begin
         if (pos_n == MSB_POS) begin
            dout  <= word[DATA_W-1];
            shreg <= {word[DATA_W-2:0], 1'b0};
         end else if (in_data) begin
            dout  <= shreg[DATA_W-1];
            shreg <= {shreg[DATA_W-2:0], 1'b0};
         end else begin
            dout  <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/adc_dual_serial_emu.sv
module adc_dual_serial_emu
   import emu_pkg::*;
#(
   parameter int unsigned DATA_W      = 12,
   parameter int unsigned LEAD_ZEROS  = 4,
   parameter int unsigned SLOT_LEN    = 16,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              sclk,
   input  logic              dual_mode,
   input  logic [DATA_W-1:0] sample_a,
   input  logic [DATA_W-1:0] sample_b,
   output logic              dout_a,
   output logic              dout_a_oe,
   output logic              dout_b,
   output logic              dout_b_oe
);

   localparam int unsigned POS_W = $clog2(SLOT_LEN + 1);

   initial begin : p_param_chk
      assert (DATA_W >= 2)
         else $fatal(1, "DATA_W must be at least 2");
      assert (SLOT_LEN >= LEAD_ZEROS + DATA_W)
         else $fatal(1, "SLOT_LEN too short for LEAD_ZEROS + DATA_W");
      assert (SYNC_STAGES <= 4)
         else $fatal(1, "SYNC_STAGES above 4 not supported");
   end

   emu_evt_t         evt;
   logic             frame_start, frame_end, fall_act, latch_en, dual_q;
   logic [POS_W-1:0] pos_n;
   slot_ch_e         slot_ch;
   logic [DATA_W-1:0] hold_a, hold_b;

   logic [DATA_W-1:0] lane_word [NUM_LANES];
   logic              lane_en   [NUM_LANES];
   logic              lane_dout [NUM_LANES];
   logic              lane_oe   [NUM_LANES];

   emu_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
      .clk   (clk),
      .rst_n (rst_n),
      .cs_n  (cs_n),
      .sclk  (sclk),
      .evt   (evt)
   );

   emu_slot_ctrl #(.SLOT_LEN(SLOT_LEN), .POS_W(POS_W)) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .evt         (evt),
      .dual_in     (dual_mode),
      .frame_start (frame_start),
      .frame_end   (frame_end),
      .fall_act    (fall_act),
      .pos_n       (pos_n),
      .latch_en    (latch_en),
      .dual_q      (dual_q),
      .slot_ch     (slot_ch)
   );

   // Both channels are captured on one event: a simultaneous sample pair
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_a <= '0;
         hold_b <= '0;
      end else if (latch_en) begin
         hold_a <= sample_a;
         hold_b <= sample_b;
      end
   end

   always_comb begin
      lane_word[0] = (!dual_q && slot_ch == SLOT_CH_B) ? hold_b : hold_a;
      lane_word[1] = hold_b;
      lane_en[0]   = 1'b1;
      lane_en[1]   = dual_mode;
   end

   generate
      for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
         emu_lane #(
            .DATA_W     (DATA_W),
            .LEAD_ZEROS (LEAD_ZEROS),
            .POS_W      (POS_W)
         ) u_lane (
            .clk         (clk),
            .rst_n       (rst_n),
            .frame_start (frame_start),
            .frame_end   (frame_end),
            .lane_en     (lane_en[l]),
            .fall_act    (fall_act),
            .pos_n       (pos_n),
            .word        (lane_word[l]),
            .dout        (lane_dout[l]),
            .oe          (lane_oe[l])
         );
      end
   endgenerate

   assign dout_a    = lane_dout[0];
   assign dout_a_oe = lane_oe[0];
   assign dout_b    = lane_dout[1];
   assign dout_b_oe = lane_oe[1];

endmodule

// File: rtl/adc_dual_serial_emu_chk.sv
module adc_dual_serial_emu_chk #(
   parameter int unsigned POS_W      = 5,
   parameter int unsigned LEAD_ZEROS = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             frame_start,
   input logic             frame_end,
   input logic             fall_act,
   input logic [POS_W-1:0] pos_n,
   input logic             dout_a,
   input logic             dout_a_oe,
   input logic             dout_b,
   input logic             dout_b_oe
);

   localparam logic [POS_W-1:0] LEAD_POS = POS_W'(LEAD_ZEROS);

   a_r2_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
      (!dout_a_oe |-> !dout_a) and (!dout_b_oe |-> !dout_b));

   a_r2_open_line_a: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |=> dout_a_oe);

   a_r8_close_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
      frame_end |=> (!dout_a_oe && !dout_b_oe));

   a_r5_b_needs_a: assert property (@(posedge clk) disable iff (!rst_n)
      dout_b_oe |-> dout_a_oe);

   a_r10_b_mode_held: assert property (@(posedge clk) disable iff (!rst_n)
      (dout_a_oe && $past(dout_a_oe)) |-> $stable(dout_b_oe));

   a_r3_lead_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (fall_act && pos_n <= LEAD_POS) |=> (!dout_a && !dout_b));

   a_r3_change_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
      (!fall_act && !frame_start && !frame_end) |=> ($stable(dout_a) && $stable(dout_b)));

endmodule

bind adc_dual_serial_emu adc_dual_serial_emu_chk #(
   .POS_W      (POS_W),
   .LEAD_ZEROS (LEAD_ZEROS)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .frame_start (frame_start),
   .frame_end   (frame_end),
   .fall_act    (fall_act),
   .pos_n       (pos_n),
   .dout_a      (dout_a),
   .dout_a_oe   (dout_a_oe),
   .dout_b      (dout_b),
   .dout_b_oe   (dout_b_oe)
);

// File: tb/adc_dual_serial_emu_tb.sv
`timescale 1ns/1ps
module adc_dual_serial_emu_tb;

   localparam int W    = 12;
   localparam int LEAD = 4;
   localparam int SLOT = 18;
   localparam int HALF = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs_n = 1'b1;
   logic sclk = 1'b1;
   logic dual_mode = 1'b0;
   logic [W-1:0] sample_a = '0;
   logic [W-1:0] sample_b = '0;
   logic dout_a, dout_a_oe, dout_b, dout_b_oe;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   adc_dual_serial_emu #(
      .DATA_W      (W),
      .LEAD_ZEROS  (LEAD),
      .SLOT_LEN    (SLOT),
      .SYNC_STAGES (2)
   ) u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .cs_n      (cs_n),
      .sclk      (sclk),
      .dual_mode (dual_mode),
      .sample_a  (sample_a),
      .sample_b  (sample_b),
      .dout_a    (dout_a),
      .dout_a_oe (dout_a_oe),
      .dout_b    (dout_b),
      .dout_b_oe (dout_b_oe)
   );

   function automatic logic exp_bit(input logic [W-1:0] w, input int k);
      if (k > LEAD && k <= LEAD + W) return w[LEAD + W - k];
      return 1'b0;
   endfunction

   task automatic chk(input logic act, input logic exp, input string req, input string what);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
      end
   endtask

   // One serial-clock fall, then sample near the end of the low phase
   task automatic fall_step();
      @(negedge clk) sclk = 1'b0;
      repeat (HALF) @(negedge clk);
   endtask

   task automatic rise_step();
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
   endtask

   task automatic open_frame(input logic dual, input string req);
      @(negedge clk);
      dual_mode = dual;
      cs_n = 1'b0;
      repeat (HALF) @(negedge clk);
      chk(dout_a_oe, 1'b1, "R2", "line A enabled after cs fall");
      chk(dout_b_oe, dual, req, "line B enable follows mode pin");
   endtask

   task automatic close_frame(input string req);
      @(negedge clk) cs_n = 1'b1;
      repeat (HALF) @(negedge clk);
      chk(dout_a_oe, 1'b0, req, "line A disabled after cs rise");
      chk(dout_b_oe, 1'b0, req, "line B disabled after cs rise");
      chk(dout_a, 1'b0, req, "line A data low when disabled");
      chk(dout_b, 1'b0, req, "line B data low when disabled");
      repeat (2 * HALF) @(negedge clk);
   endtask

   // Full slot; checks R3 ordering and R11 trailing zeros on every edge
   task automatic run_slot(input logic [W-1:0] ea, input logic [W-1:0] eb,
                           input bit exp_b_on, input bit chg,
                           input logic [W-1:0] na, input logic [W-1:0] nb,
                           input string req);
      for (int k = 1; k <= SLOT; k++) begin
         fall_step();
         chk(dout_a, exp_bit(ea, k), req, $sformatf("line A bit at fall %0d", k));
         chk(dout_b_oe, exp_b_on, req, $sformatf("line B enable at fall %0d", k));
         chk(dout_b, exp_b_on ? exp_bit(eb, k) : 1'b0, req,
             $sformatf("line B bit at fall %0d", k));
         rise_step();
         if (chg && k == 8) begin
            sample_a = na;
            sample_b = nb;
         end
      end
   endtask

   task automatic t_reset();
      repeat (2) @(negedge clk);
      chk(dout_a_oe, 1'b0, "R1", "reset enable A");
      chk(dout_b_oe, 1'b0, "R1", "reset enable B");
      chk(dout_a, 1'b0, "R1", "reset data A");
      chk(dout_b, 1'b0, "R1", "reset data B");
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
   endtask

   task automatic t_idle_clock();
      for (int k = 0; k < 5; k++) begin
         fall_step();
         chk(dout_a_oe, 1'b0, "R9", "no enable for idle clock");
         chk(dout_a, 1'b0, "R9", "no data for idle clock");
         rise_step();
      end
      sample_a = 12'h9C3;
      sample_b = 12'h13F;
      open_frame(1'b1, "R4");
      // Slot must start at position 1 despite the idle falls (R9)
      run_slot(12'h9C3, 12'h13F, 1'b1, 1'b0, '0, '0, "R9");
      close_frame("R2");
   endtask

   task automatic t_dual_frame();
      sample_a = 12'h5A3;
      sample_b = 12'hA5C;
      open_frame(1'b1, "R4");
      run_slot(12'h5A3, 12'hA5C, 1'b1, 1'b1, 12'h7FF, 12'h800, "R7");
      dual_mode = 1'b0;   // R10: ignored until the next frame
      run_slot(12'h7FF, 12'h800, 1'b1, 1'b0, '0, '0, "R6");
      run_slot(12'h7FF, 12'h800, 1'b1, 1'b0, '0, '0, "R10");
      close_frame("R2");
   endtask

   task automatic t_single_frame();
      sample_a = 12'h123;
      sample_b = 12'hFED;
      open_frame(1'b0, "R5");
      run_slot(12'h123, '0, 1'b0, 1'b1, 12'h000, 12'h001, "R5");
      // Channel B word comes from the same capture as the A word (R7)
      run_slot(12'hFED, '0, 1'b0, 1'b0, '0, '0, "R7");
      run_slot(12'h000, '0, 1'b0, 1'b0, '0, '0, "R6");
      run_slot(12'h001, '0, 1'b0, 1'b0, '0, '0, "R11");
      close_frame("R2");
   endtask

   task automatic t_abort();
      sample_a = 12'h456;
      sample_b = 12'hBA9;
      open_frame(1'b1, "R4");
      for (int k = 1; k <= 7; k++) begin
         fall_step();
         chk(dout_a, exp_bit(12'h456, k), "R8", $sformatf("partial A bit %0d", k));
         chk(dout_b, exp_bit(12'hBA9, k), "R8", $sformatf("partial B bit %0d", k));
         rise_step();
      end
      close_frame("R8");
      sample_a = 12'h321;
      sample_b = 12'hCDE;
      open_frame(1'b1, "R4");
      run_slot(12'h321, 12'hCDE, 1'b1, 1'b0, '0, '0, "R8");
      close_frame("R8");
   endtask

   initial begin
      t_reset();
      t_idle_clock();
      t_dual_frame();
      t_single_frame();
      t_abort();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

endmodule